// File: doc/BRIEF.md
# Debug-Mode Watchdog Supervisor

This block decides, once per boot, whether the device should run with watchdog checking suspended. After a synchronous reset it holds a boot phase of `INIT_LEN` clocks, then spends one clock in an init phase, and then settles in either a debug state or a supervised state. The choice depends only on the value of `dbg_win` in the last clock of the boot phase. `dbg_win` is a pre-qualified, already synchronised flag. It is true when an external debug voltage sits inside its valid window.

In the debug state the watchdog is dormant. Refresh strobes are ignored and no timeout can occur. The block leaves debug when `dbg_win` drops, or when software writes the leave code to the command port. The software command overrides a window that is still valid and locks debug out until the next external reset. In the supervised state a down-counter must be refreshed through `wd_kick` within `TIMEOUT` clocks. If it is not, the block emits a one-clock `rst_req` pulse and restarts its boot phase, which re-evaluates `dbg_win` unless the lock is set.

Top module: `dbg_wd_supervisor`

## Requirements
- R1: While `rst` is high, and for the `INIT_LEN` boot clocks plus the one init clock that follow its release, `dbg_active`, `wd_active` and `rst_req` are all low.
- R2: Debug is entered one clock after the init phase exactly when `dbg_win` was high in the final boot clock. Its value in any other clock of the boot or init phase has no effect.
- R3: While in debug, `rst_req` stays low no matter how long it lasts, and `wd_kick` pulses change nothing that is visible on the outputs.
- R4: If `dbg_win` is low in a debug clock, the next clock is supervised (`wd_active` high, `dbg_active` low).
- R5: A write (`reg_wr` high) whose `reg_wdata` equals `LEAVE_CODE` (default 8'hA5) moves a debug block to supervised in the next clock even with `dbg_win` high. Writes of any other value, and the leave value with `reg_wr` low, are ignored.
- R6: After a leave write, debug is never entered again, across watchdog-triggered reboots, until `rst` is asserted.
- R7: In the supervised state, with its first clock counted as clock 0 and a refresh counting in the clock it is presented, `rst_req` rises in clock `k+TIMEOUT+1`, where `k` is the last refresh clock (or -1 if there was none). `rst_req` lasts one clock, `wd_active` drops in that same clock, and the boot phase then restarts.
- R8: A window drop and a leave write in the same debug clock give a single entry into supervision with the full `TIMEOUT` budget.
- R9: `dbg_active` is high exactly in the debug state and `wd_active` exactly in the supervised state. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also clears the leave lock |
| dbg_win | input | 1 | Debug voltage inside its window (pre-synchronised) |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | DATA_W | Command register write value |
| wd_kick | input | 1 | Watchdog refresh strobe |
| dbg_active | output | 1 | Debug status flag |
| wd_active | output | 1 | Watchdog supervision running |
| rst_req | output | 1 | One-clock reset request on watchdog timeout |

## Verification
The assertions assume that `dbg_win`, `reg_wr`, `reg_wdata` and `wd_kick` are synchronous to `clk` and settle well before each rising edge. They also assume that a command write is a single-clock strobe. The bench changes every input only on falling edges and pulses `reg_wr` and `wd_kick` for exactly one clock. `dbg_win` is held as a level for many clocks, so each step of the window and each command lands in one known clock of the state sequence.

// File: rtl/dbgsup_pkg.sv
package dbgsup_pkg;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_INIT  = 2'd1,
        ST_DEBUG = 2'd2,
        ST_SUPV  = 2'd3
    } sup_state_e;

    // Per-clock input events after decoding
    typedef struct packed {
        logic win;
        logic leave;
        logic kick;
    } sup_evt_t;

    // Decisions produced by the next-state logic
    typedef struct packed {
        sup_state_e nxt;
        logic       entry_d;
        logic       wd_load;
        logic       req_d;
    } sup_ctl_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dbgsup_phase_timer.sv
module dbgsup_phase_timer
    import dbgsup_pkg::*;
#(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int unsigned W = cnt_w(LEN);
    localparam logic [W-1:0] LAST_VAL = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST_VAL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == LAST_VAL);

endmodule

// File: rtl/dbgsup_wd_counter.sv
module dbgsup_wd_counter
    import dbgsup_pkg::*;
#(
    parameter int unsigned TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int unsigned W = cnt_w(TIMEOUT);
    localparam logic [W-1:0] RELOAD = W'(TIMEOUT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            if (kick) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire = run && !kick && (cnt_q == '0);

endmodule

// File: rtl/dbgsup_exit_lock.sv
module dbgsup_exit_lock (
    input  logic clk,
    input  logic rst,
    input  logic leave,
    output logic blocked
);
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
        end else if (leave) begin
            locked_q <= 1'b1;
        end
    end

    // A leave in the current clock blocks entry as well
    assign blocked = locked_q || leave;

endmodule

// File: rtl/dbg_wd_supervisor.sv
module dbg_wd_supervisor
    import dbgsup_pkg::*;
#(
    parameter int unsigned TIMEOUT    = 1024,
    parameter int unsigned INIT_LEN   = 16,
    parameter int unsigned DATA_W     = 8,
    parameter logic [DATA_W-1:0] LEAVE_CODE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_win,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wd_kick,
    output logic              dbg_active,
    output logic              wd_active,
    output logic              rst_req
);
    sup_state_e state_q;
    logic       entry_q;
    logic       req_q;
    sup_evt_t   evt;
    sup_ctl_t   ctl;
    logic       boot_last;
    logic       blocked;
    logic       wd_expire;

    assign evt.win   = dbg_win;
    assign evt.leave = reg_wr && (reg_wdata == LEAVE_CODE);
    assign evt.kick  = wd_kick;

    dbgsup_phase_timer #(.LEN(INIT_LEN)) u_boot (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q == ST_BOOT),
        .last (boot_last)
    );

    dbgsup_exit_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .leave   (evt.leave),
        .blocked (blocked)
    );

    dbgsup_wd_counter #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.wd_load),
        .run    (state_q == ST_SUPV),
        .kick   (evt.kick),
        .expire (wd_expire)
    );

    always_comb begin
        ctl.nxt     = state_q;
        ctl.entry_d = entry_q;
        ctl.wd_load = 1'b0;
        ctl.req_d   = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                if (boot_last) begin
                    ctl.nxt     = ST_INIT;
                    ctl.entry_d = evt.win && !blocked;
                end
            end
            ST_INIT: begin
                if (entry_q && !blocked) begin
                    ctl.nxt = ST_DEBUG;
                end else begin
                    ctl.nxt     = ST_SUPV;
                    ctl.wd_load = 1'b1;
                end
            end
            ST_DEBUG: begin
                if (evt.leave || !evt.win) begin
                    ctl.nxt     = ST_SUPV;
                    ctl.wd_load = 1'b1;
                end
            end
            ST_SUPV: begin
                if (wd_expire) begin
                    ctl.nxt   = ST_BOOT;
                    ctl.req_d = 1'b1;
                end
            end
            default: ctl.nxt = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            entry_q <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            state_q <= ctl.nxt;
            entry_q <= ctl.entry_d;
            req_q   <= ctl.req_d;
        end
    end

    assign dbg_active = (state_q == ST_DEBUG);
    assign wd_active  = (state_q == ST_SUPV);
    assign rst_req    = req_q;

endmodule

// File: rtl/dbg_wd_supervisor_chk.sv
module dbg_wd_supervisor_chk #(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] LEAVE_CODE = 8'hA5
) (
    input logic              clk,
    input logic              rst,
    input logic              dbg_win,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              dbg_active,
    input logic              wd_active,
    input logic              rst_req
);
    logic leave_now;
    logic leave_seen_q;

    assign leave_now = reg_wr && (reg_wdata == LEAVE_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            leave_seen_q <= 1'b0;
        end else if (leave_now) begin
            leave_seen_q <= 1'b1;
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(dbg_active && wd_active)); // R9

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R7

    AST_REQ_AFTER_SUPV: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(wd_active) && !wd_active)); // R7

    AST_DEBUG_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        dbg_active |=> !rst_req); // R3

    AST_WIN_DROP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (dbg_active && !dbg_win) |=> (wd_active && !dbg_active)); // R4

    AST_LEAVE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (dbg_active && leave_now) |=> (wd_active && !dbg_active)); // R5

    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        leave_seen_q |-> !$rose(dbg_active)); // R6

endmodule

bind dbg_wd_supervisor dbg_wd_supervisor_chk #(
    .DATA_W     (DATA_W),
    .LEAVE_CODE (LEAVE_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_win    (dbg_win),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .dbg_active (dbg_active),
    .wd_active  (wd_active),
    .rst_req    (rst_req)
);

// File: tb/dbg_wd_supervisor_test.sv
module dbg_wd_supervisor_test;
    localparam int PERIOD = 10;
    localparam int T      = 8;
    localparam int L      = 3;
    localparam logic [7:0] LEAVE = 8'hA5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbg_win = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       wd_kick = 1'b0;
    logic       dbg_active, wd_active, rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    dbg_wd_supervisor #(
        .TIMEOUT(T), .INIT_LEN(L), .DATA_W(8), .LEAVE_CODE(LEAVE)
    ) uut (
        .clk(clk), .rst(rst), .dbg_win(dbg_win), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .wd_kick(wd_kick), .dbg_active(dbg_active),
        .wd_active(wd_active), .rst_req(rst_req)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic win);
        rst = 1'b1; dbg_win = win; reg_wr = 1'b0; wd_kick = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "dbg in reset", int'(dbg_active), 0);
        chk("R1", "wd in reset", int'(wd_active), 0);
        chk("R1", "req in reset", int'(rst_req), 0);
        rst = 1'b0;
    endtask

    task automatic boot(input logic win);
        do_reset(win);
        repeat (L + 1) @(negedge clk);
    endtask

    task automatic leave_write();
        reg_wr = 1'b1; reg_wdata = LEAVE;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    // Current clock is supervised clock 0; gap 0 means no refresh at all.
    task automatic wd_watch(input int gap, input string req);
        int last = -1;
        for (int c = 0; c <= 4 * T; c++) begin
            if (c == last + T + 1) begin
                chk(req, "rst_req at deadline", int'(rst_req), 1);
                chk(req, "wd_active at deadline", int'(wd_active), 0);
                @(negedge clk);
                chk("R7", "rst_req one clock", int'(rst_req), 0);
                return;
            end
            chk(req, "rst_req before deadline", int'(rst_req), 0);
            chk(req, "wd_active before deadline", int'(wd_active), 1);
            wd_kick = (gap != 0) && (c % gap == 0);
            if (wd_kick) last = c;
            @(negedge clk);
            wd_kick = 1'b0;
        end
    endtask

    initial begin
        // R1: flags held low through boot and init
        do_reset(1'b1);
        for (int i = 0; i <= L; i++) begin
            chk("R1", "dbg during boot", int'(dbg_active), 0);
            chk("R1", "wd during boot", int'(wd_active), 0);
            @(negedge clk);
        end
        chk("R9", "debug flag after boot", int'(dbg_active), 1);
        chk("R9", "wd flag in debug", int'(wd_active), 0);

        // R2: window rising in clock i, held; only final boot clock counts
        for (int i = 0; i <= L + 2; i++) begin
            do_reset(1'b0);
            for (int c = 0; c <= L + 3; c++) begin
                if (c == i) dbg_win = 1'b1;
                @(negedge clk);
            end
            chk("R2", $sformatf("dbg rise@%0d", i), int'(dbg_active), int'(i <= L - 1));
            chk("R2", $sformatf("wd rise@%0d", i), int'(wd_active), int'(i > L - 1));
        end
        // R2: window high in boot then low at the sampled clock
        do_reset(1'b1);
        for (int c = 0; c <= L + 3; c++) begin
            dbg_win = (c != L - 1);
            @(negedge clk);
        end
        chk("R2", "window dip at sample", int'(dbg_active), 0);

        // R3: long debug stay with refreshes, no request
        boot(1'b1);
        for (int c = 0; c < 3 * T; c++) begin
            wd_kick = c[0];
            @(negedge clk);
            chk("R3", "req in debug", int'(rst_req), 0);
            chk("R3", "still debug", int'(dbg_active), 1);
        end
        wd_kick = 1'b0;

        // R4: window drop, full budget, then reboot re-samples
        dbg_win = 1'b0;
        @(negedge clk);
        chk("R4", "dbg after drop", int'(dbg_active), 0);
        chk("R4", "wd after drop", int'(wd_active), 1);
        wd_watch(0, "R7");
        dbg_win = 1'b1;
        repeat (L) @(negedge clk);
        chk("R7", "reboot re-enters debug", int'(dbg_active), 1);

        // R5: wrong code and missing strobe ignored, then leave works
        boot(1'b1);
        reg_wr = 1'b1; reg_wdata = 8'h5A;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = LEAVE;
        @(negedge clk);
        reg_wdata = 8'h00;
        chk("R5", "ignored writes", int'(dbg_active), 1);
        leave_write();
        chk("R5", "dbg after leave", int'(dbg_active), 0);
        chk("R5", "wd after leave", int'(wd_active), 1);

        // R6: lock survives watchdog reboot with window still high
        wd_watch(0, "R6");
        repeat (L) @(negedge clk);
        chk("R6", "no reentry dbg", int'(dbg_active), 0);
        chk("R6", "no reentry wd", int'(wd_active), 1);
        boot(1'b1);
        chk("R6", "reset clears lock", int'(dbg_active), 1);

        // R8: drop and leave together
        dbg_win = 1'b0;
        leave_write();
        chk("R8", "single entry dbg", int'(dbg_active), 0);
        wd_watch(0, "R8");

        // R7: refresh interval sweep
        for (int g = 1; g <= T + 2; g++) begin
            boot(1'b0);
            wd_watch(g, "R7");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule